// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers a parameterised set of interrupt inputs, up to 32, from pins or peripherals and conditions each one before it reaches the processor. Every input is first brought into the system clock domain. A per-source detection mode then decides what counts as an event: the level itself, a rising edge, a falling edge, or either edge. Edge events are held in a sticky latch until software clears them by writing 1. Level sources show the live synchronized level.

Each source has its own enable and its own class bit, fast or normal. The block drives one request line for each class. A request line is high while any enabled source of that class has its pending bit set. The pending vector is always visible, so software can see every source that fired, including several that fired in the same cycle. A pending bit still latches while its source is disabled, but it raises no request until the source is enabled.

The configuration vectors arrive as plain inputs from a register block outside this module. The clear strobe and mask come from the same place. The reset is asynchronous and active-low, and is expected to be released in step with the clock.

Top module: `irq_cond_ctrl`

## Requirements
- R1: While reset is active and right after it, every pending bit and both request outputs are 0.
- R2: Each input passes through two clocked stages before detection. A level change driven before clock edge k shows on a level-mode pending bit after edge k+1 and not before. An edge-mode pending bit sets after edge k+2.
- R3: Mode code 0 (level): the pending bit equals the synchronized input. A write-1 clear has no effect on it. Putting a source into level mode discards any edge latch it held.
- R4: Mode code 1 (rising): a synchronized 0 to 1 transition sets the sticky pending bit. The bit stays set after the input falls.
- R5: Mode code 2 (falling): a synchronized 1 to 0 transition sets the sticky pending bit.
- R6: Mode code 3 (both): either transition sets the sticky pending bit.
- R7: When the clear strobe is high at a clock edge, each edge-mode pending bit whose mask bit is 1 goes to 0. Bits whose mask bit is 0 are untouched. A new event in the same cycle wins over the clear.
- R8: A pending bit latches regardless of its enable. A disabled source never drives either request output.
- R9: The fast request is the OR over all sources of pending AND enable AND class bit = 1. The normal request is the same with class bit = 0. Both are combinational from pending and configuration.
- R10: Events on several sources in the same cycle all latch together. Mode bits for source i sit at cfg_mode[2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt inputs, any clock domain |
| cfg_mode | input | 2*NUM_SRC | Per-source detection code: 0 level, 1 rising, 2 falling, 3 both |
| cfg_enable | input | NUM_SRC | Per-source request enable |
| cfg_fast | input | NUM_SRC | Per-source class: 1 fast, 0 normal |
| clr_we | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | NUM_SRC | Bits to clear when clr_we is high |
| pending | output | NUM_SRC | Pending status per source |
| irq_fast | output | 1 | Request for the fast class |
| irq_norm | output | 1 | Request for the normal class |

## Verification
The bench builds the block with NUM_SRC = 8 and SYNC_STAGES = 2. With 8 sources, one directed pass can give every detection code its own source and still leave four sources for a burst of simultaneous edges. It can also mix enabled and disabled sources across both classes. A long random phase then changes modes, enables, classes, inputs and clear masks together. This covers clears that coincide with new edges, mode switches on latched sources, and requests that come and go as enables change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;
endpackage

// File: rtl/irqc_sync.sv
// Multi-stage synchronizer bank for a vector of asynchronous inputs.
module irqc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/irqc_src_cell.sv
// Per-source detector: edge compare against previous sample plus sticky latch.
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_i,
  input  det_mode_e mode_i,
  input  logic      clr_i,
  output logic      pend_o
);
  logic prev_q, prev_d;
  logic sticky_q, sticky_d;
  logic rise, fall, evt;

  always_comb begin
    rise   = lvl_i & ~prev_q;
    fall   = ~lvl_i & prev_q;
    prev_d = lvl_i;
    unique case (mode_i)
      DET_RISE: evt = rise;
      DET_FALL: evt = fall;
      DET_BOTH: evt = rise | fall;
      default:  evt = 1'b0;
    endcase
    if (mode_i == DET_LEVEL) sticky_d = 1'b0;
    else                     sticky_d = evt | (sticky_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign pend_o = (mode_i == DET_LEVEL) ? lvl_i : sticky_q;

  assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_RISE && lvl_i && !prev_q) |=> sticky_q);

  assert_fall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_FALL && !lvl_i && prev_q) |=> sticky_q);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != DET_LEVEL && clr_i && !evt) |=> !sticky_q);

  assert_level_drops_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DET_LEVEL) |=> !sticky_q);
endmodule

// File: rtl/irqc_req_merge.sv
// Class request reduction over all sources.
module irqc_req_merge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] fast_i,
  output logic         irq_fast_o,
  output logic         irq_norm_o
);
  logic [N-1:0] live;

  always_comb begin
    live       = pend_i & en_i;
    irq_fast_o = |(live & fast_i);
    irq_norm_o = |(live & ~fast_i);
  end

  assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & en_i) == '0) |-> (!irq_fast_o && !irq_norm_o));

  assert_norm_needs_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_i & ~fast_i) == '0) |-> !irq_norm_o);
endmodule

// File: rtl/irq_cond_ctrl.sv
module irq_cond_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic [2*NUM_SRC-1:0] cfg_mode,
  input  logic [NUM_SRC-1:0]   cfg_enable,
  input  logic [NUM_SRC-1:0]   cfg_fast,
  input  logic                 clr_we,
  input  logic [NUM_SRC-1:0]   clr_mask,
  output logic [NUM_SRC-1:0]   pending,
  output logic                 irq_fast,
  output logic                 irq_norm
);
  localparam int MODE_W = 2;

  logic [NUM_SRC-1:0] lvl_sync;
  logic [NUM_SRC-1:0] clr_vec;

  assign clr_vec = {NUM_SRC{clr_we}} & clr_mask;

  irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_in),
    .q_o   (lvl_sync)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    det_mode_e mode_i;
    assign mode_i = det_mode_e'(cfg_mode[MODE_W*i +: MODE_W]);

    irqc_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl_sync[i]),
      .mode_i (mode_i),
      .clr_i  (clr_vec[i]),
      .pend_o (pending[i])
    );
  end

  irqc_req_merge #(.N(NUM_SRC)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pending),
    .en_i       (cfg_enable),
    .fast_i     (cfg_fast),
    .irq_fast_o (irq_fast),
    .irq_norm_o (irq_norm)
  );
endmodule

// File: tb/irq_cond_ctrl_tb.sv
`timescale 1ns/1ps
module irq_cond_ctrl_tb;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src_in = '0;
  logic [2*N-1:0] cfg_mode = '0;
  logic [N-1:0]   cfg_enable = '0;
  logic [N-1:0]   cfg_fast = '0;
  logic           clr_we = 1'b0;
  logic [N-1:0]   clr_mask = '0;
  logic [N-1:0]   pending;
  logic           irq_fast, irq_norm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_cond_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_mode(cfg_mode),
    .cfg_enable(cfg_enable), .cfg_fast(cfg_fast), .clr_we(clr_we),
    .clr_mask(clr_mask), .pending(pending), .irq_fast(irq_fast), .irq_norm(irq_norm)
  );

  // Behavioural reference: sample history per source and an event latch.
  bit hist0 [N];
  bit hist1 [N];
  bit hist2 [N];
  bit latch [N];

  function automatic int mode_of(int i);
    return int'(cfg_mode[2*i +: 2]);
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        hist0[i] = 0; hist1[i] = 0; hist2[i] = 0; latch[i] = 0;
      end else begin
        bit up, down, hit;
        up   = hist1[i] && !hist2[i];
        down = !hist1[i] && hist2[i];
        case (mode_of(i))
          1: hit = up;
          2: hit = down;
          3: hit = up || down;
          default: hit = 0;
        endcase
        if (mode_of(i) == 0) latch[i] = 0;
        else if (hit) latch[i] = 1;
        else if (clr_we && clr_mask[i]) latch[i] = 0;
        hist2[i] = hist1[i];
        hist1[i] = hist0[i];
        hist0[i] = src_in[i];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] ep;
      logic ef, en;
      for (int i = 0; i < N; i++) ep[i] = (mode_of(i) == 0) ? hist1[i] : latch[i];
      ef = 0; en = 0;
      for (int i = 0; i < N; i++) begin
        if (ep[i] && cfg_enable[i] && cfg_fast[i])  ef = 1;
        if (ep[i] && cfg_enable[i] && !cfg_fast[i]) en = 1;
      end
      checks++;
      if (pending !== ep) begin
        errors++;
        $display("FAIL R10 model pending act=%h exp=%h t=%0t", pending, ep, $time);
      end
      checks++;
      if (irq_fast !== ef || irq_norm !== en) begin
        errors++;
        $display("FAIL R9 model requests act=%b%b exp=%b%b t=%0t", irq_fast, irq_norm, ef, en, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic set_mode(input int i, input logic [1:0] m);
    cfg_mode[2*i +: 2] = m;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    step(3);
    chk(pending == '0 && !irq_fast && !irq_norm, "R1 reset state", {pending, irq_fast, irq_norm}, 0);
    rst_n = 1'b1;
    step(1);
    chk(pending == '0 && !irq_fast && !irq_norm, "R1 after release", {pending, irq_fast, irq_norm}, 0);

    // R2 / R3: level mode latency and clear immunity on source 0
    src_in[0] = 1'b1;
    step(1);
    chk(pending[0] == 1'b0, "R2 not yet visible", pending[0], 0);
    step(1);
    chk(pending[0] == 1'b1, "R2 level after two stages", pending[0], 1);
    clr_we = 1'b1; clr_mask = 8'h01;
    step(1);
    clr_we = 1'b0; clr_mask = '0;
    chk(pending[0] == 1'b1, "R3 level ignores clear", pending[0], 1);
    src_in[0] = 1'b0;
    step(2);
    chk(pending[0] == 1'b0, "R3 level follows input", pending[0], 0);

    // R4: rising on source 1
    set_mode(1, 2'd1);
    src_in[1] = 1'b1;
    step(2);
    chk(pending[1] == 1'b0, "R2 edge not yet latched", pending[1], 0);
    step(1);
    chk(pending[1] == 1'b1, "R4 rising latched", pending[1], 1);
    src_in[1] = 1'b0;
    step(3);
    chk(pending[1] == 1'b1, "R4 sticky after fall", pending[1], 1);
    clr_we = 1'b1; clr_mask = 8'h02;
    step(1);
    clr_we = 1'b0; clr_mask = '0;
    chk(pending[1] == 1'b0, "R7 cleared by write one", pending[1], 0);

    // R5: falling on source 2
    set_mode(2, 2'd2);
    src_in[2] = 1'b1;
    step(3);
    chk(pending[2] == 1'b0, "R5 rising ignored", pending[2], 0);
    src_in[2] = 1'b0;
    step(3);
    chk(pending[2] == 1'b1, "R5 falling latched", pending[2], 1);

    // R6: both edges on source 3
    set_mode(3, 2'd3);
    src_in[3] = 1'b1;
    step(3);
    chk(pending[3] == 1'b1, "R6 rise latched", pending[3], 1);
    clr_we = 1'b1; clr_mask = 8'h08;
    step(1);
    clr_we = 1'b0; clr_mask = '0;
    chk(pending[3] == 1'b0, "R6 cleared", pending[3], 0);
    src_in[3] = 1'b0;
    step(3);
    chk(pending[3] == 1'b1, "R6 fall latched", pending[3], 1);

    // R8 / R9: enables and classes
    chk(pending[3:2] == 2'b11 && !irq_fast && !irq_norm, "R8 disabled latch no request",
        {pending, irq_fast, irq_norm}, {8'h0c, 2'b00});
    cfg_enable[3] = 1'b1;
    step(1);
    chk(irq_norm && !irq_fast, "R9 normal class request", {irq_fast, irq_norm}, 2'b01);
    cfg_fast[3] = 1'b1;
    step(1);
    chk(irq_fast && !irq_norm, "R9 fast class request", {irq_fast, irq_norm}, 2'b10);
    cfg_enable[2] = 1'b1;
    step(1);
    chk(irq_fast && irq_norm, "R9 both classes", {irq_fast, irq_norm}, 2'b11);

    // R10: simultaneous rising edges on sources 4..7
    for (int i = 4; i < 8; i++) set_mode(i, 2'd1);
    src_in[7:4] = 4'hF;
    step(3);
    chk(pending[7:4] == 4'hF, "R10 simultaneous latch", pending[7:4], 4'hF);
    clr_we = 1'b1; clr_mask = 8'h50;
    step(1);
    clr_we = 1'b0; clr_mask = '0;
    chk(pending[7:4] == 4'hA, "R7 masked clear only", pending[7:4], 4'hA);

    // R3: switching a latched source to level drops the latch
    set_mode(5, 2'd0);
    src_in[5] = 1'b0;
    step(3);
    set_mode(5, 2'd1);
    step(1);
    chk(pending[5] == 1'b0, "R3 level mode discards latch", pending[5], 0);

    // Random phase, compared against the reference every cycle
    for (int c = 0; c < 4000; c++) begin
      src_in = src_in ^ N'($urandom & $urandom);
      if ($urandom_range(0, 7) == 0) cfg_mode = 16'($urandom);
      if ($urandom_range(0, 5) == 0) cfg_enable = N'($urandom);
      if ($urandom_range(0, 5) == 0) cfg_fast = N'($urandom);
      clr_we = ($urandom_range(0, 3) == 0);
      clr_mask = N'($urandom);
      step(1);
    end
    clr_we = 1'b0;

    // R1: reset mid-run returns everything to zero
    rst_n = 1'b0;
    step(1);
    chk(pending == '0 && !irq_fast && !irq_norm, "R1 reset mid run", {pending, irq_fast, irq_norm}, 0);
    finish_run();
  end
endmodule